// File: doc/BRIEF.md
# Divide-Ratio to Preset-Word Converter

This block turns a binary divide ratio and a choice of first-stage modulus into the sixteen preset bits and the three mode-select levels that a programmable divide-by-N down-counter needs. The ratio is divided by the selected modulus (2, 4, 5, 8 or 10). The remainder becomes the preset of the fast first stage. The quotient is broken into decimal digits: ones, tens and hundreds go to the three decade fields, and the thousands digit goes into the preset bits of the first stage that the remainder does not use.

All arithmetic is done by repeated subtraction, one step per clock. The division takes one cycle per unit of quotient. The decimal split takes one cycle per unit of each digit. A caller pulses `start` while the block is idle, watches `busy`, and reads the registered outputs when `done` pulses. Requests the counter cannot reach are rejected through `err`, and the previous preset word is left untouched.

Top module: `divjam_conv`

## Requirements
- R1: After reset `busy`, `done` and `err` are low, and `jam` and `ksel` are all zeros.
- R2: A `start` seen while idle with a legal request raises `busy` on the next cycle. `busy` stays high until the cycle in which `done` is high. `done` is high for exactly one cycle, and `busy` is low in that cycle.
- R3: `mode_code` 0,1,2,3,4 selects modulus 2,4,5,8,10. The remainder of ratio/modulus is placed in the low bits of `jam[3:0]`, using 1,2,3,3,4 bits respectively (bit 0 is the LSB).
- R4: The quotient's ones digit goes to `jam[7:4]`, its tens digit to `jam[11:8]` and its hundreds digit to `jam[15:12]`, each in BCD with the lowest bit as LSB. The thousands digit sits in `jam[3:0]` directly above the remainder field.
- R5: On success `ksel` (bit 2 = first line, bit 0 = third line) is 3'b111 for modulus 2, 3'b011 for 4, 3'b101 for 5, 3'b001 for 8 and 3'b110 for 10.
- R6: A ratio below 3 is rejected. A ratio above 9999 is rejected for modulus 5 or 10, and a ratio above 15999 for modulus 2, 4 or 8. A `mode_code` of 5, 6 or 7 is rejected. A rejection gives `done` with `err` high one cycle after `start`, and `jam` and `ksel` keep their previous values.
- R7: A result is accepted only if its thousands digit fits the spare bits. The limit is 7, 3, 1, 1 or 0 for modulus 2, 4, 5, 8 or 10. Every legal ratio, including the range maxima, is then accepted.
- R8: `start` pulses while `busy` is high are ignored. The pending result belongs to the first request, and only one `done` is produced.
- R9: `err` holds the outcome of the most recent request until the next `done`. A successful request clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request pulse, accepted only when idle |
| ratio | input | 14 | Binary divide ratio N |
| mode_code | input | 3 | First-stage modulus select (0..4) |
| busy | output | 1 | Conversion in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Outcome of the last request (1 = rejected) |
| jam | output | 16 | Preset bits, bit 0 = first preset line |
| ksel | output | 3 | Mode-select levels for the counter |

## Verification
Some properties are checked by the assertions on every cycle:
- `done` is a single-cycle pulse that never overlaps `busy`.
- The preset word and select lines move only in a `done` cycle, and never on a rejection.
- Every accepted select code is one of the five legal patterns.
- The divider's remainder is always below the modulus, and every split digit is decimal.

Other properties only the directed scenarios can show:
- The actual numeric packing for each modulus, including the range boundaries.
- The worked ratio 8479 with modulus 5.
- That a second `start` during a conversion leaves the first result intact.

// File: rtl/divjam_pkg.sv
package divjam_pkg;

  localparam int RATIO_W = 14;
  localparam int QUO_W   = 13;
  localparam int MOD_W   = 4;
  localparam int DIG_W   = 4;
  localparam int PLACES  = 3;
  localparam int JAM_W   = DIG_W * (PLACES + 1);
  localparam int SEL_W   = 3;
  localparam int MODE_W  = 3;

  typedef enum logic [MODE_W-1:0] {
    MD_DIV2  = 3'd0,
    MD_DIV4  = 3'd1,
    MD_DIV5  = 3'd2,
    MD_DIV8  = 3'd3,
    MD_DIV10 = 3'd4
  } first_mode_e;

  function automatic logic mode_known(input logic [MODE_W-1:0] m);
    return m <= MD_DIV10;
  endfunction

  function automatic logic [MOD_W-1:0] mod_of(input logic [MODE_W-1:0] m);
    case (m)
      MD_DIV2:  return MOD_W'(2);
      MD_DIV4:  return MOD_W'(4);
      MD_DIV5:  return MOD_W'(5);
      MD_DIV8:  return MOD_W'(8);
      default:  return MOD_W'(10);
    endcase
  endfunction

  function automatic int rem_bits_of(input logic [MODE_W-1:0] m);
    case (m)
      MD_DIV2: return 1;
      MD_DIV4: return 2;
      MD_DIV5: return 3;
      MD_DIV8: return 3;
      default: return 4;
    endcase
  endfunction

  function automatic logic [DIG_W-1:0] last_cap(input logic [MODE_W-1:0] m);
    case (m)
      MD_DIV2: return DIG_W'(7);
      MD_DIV4: return DIG_W'(3);
      MD_DIV5: return DIG_W'(1);
      MD_DIV8: return DIG_W'(1);
      default: return DIG_W'(0);
    endcase
  endfunction

  function automatic logic [RATIO_W-1:0] ratio_max(input logic [MODE_W-1:0] m);
    case (m)
      MD_DIV5, MD_DIV10: return RATIO_W'(9999);
      default:           return RATIO_W'(15999);
    endcase
  endfunction

  function automatic logic [SEL_W-1:0] kline_of(input logic [MODE_W-1:0] m);
    case (m)
      MD_DIV2: return 3'b111;
      MD_DIV4: return 3'b011;
      MD_DIV5: return 3'b101;
      MD_DIV8: return 3'b001;
      default: return 3'b110;
    endcase
  endfunction

  function automatic logic [DIG_W-1:0] pack_low(input logic [MODE_W-1:0] m,
                                                input logic [MOD_W-1:0] r,
                                                input logic [DIG_W-1:0] th);
    case (rem_bits_of(m))
      1:       return {th[2:0], r[0]};
      2:       return {th[1:0], r[1:0]};
      3:       return {th[0], r[2:0]};
      default: return r;
    endcase
  endfunction

endpackage

// File: rtl/divjam_div_unit.sv
module divjam_div_unit #(
  parameter int N_W = divjam_pkg::RATIO_W,
  parameter int Q_W = divjam_pkg::QUO_W,
  parameter int M_W = divjam_pkg::MOD_W
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           go,
  input  logic [N_W-1:0] dividend,
  input  logic [M_W-1:0] divisor,
  output logic [Q_W-1:0] quo,
  output logic [M_W-1:0] rem,
  output logic           fin
);
  logic [N_W-1:0] acc_q;
  logic [Q_W-1:0] cnt_q;
  logic [M_W-1:0] dv_q;
  logic           run_q;
  logic [N_W-1:0] dv_ext;
  logic           step_ok;

  assign dv_ext  = N_W'(dv_q);
  assign step_ok = acc_q >= dv_ext;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
      cnt_q <= '0;
      dv_q  <= '0;
      run_q <= 1'b0;
      fin   <= 1'b0;
    end else begin
      fin <= 1'b0;
      if (go) begin
        acc_q <= dividend;
        cnt_q <= '0;
        dv_q  <= divisor;
        run_q <= 1'b1;
      end else if (run_q) begin
        if (step_ok) begin
          acc_q <= acc_q - dv_ext;
          cnt_q <= cnt_q + 1'b1;
        end else begin
          run_q <= 1'b0;
          fin   <= 1'b1;
        end
      end
    end
  end

  assign quo = cnt_q;
  assign rem = acc_q[M_W-1:0];

  // R3: remainder handed on is always below the modulus
  a_r3_rem_below_mod: assert property (@(posedge clk) disable iff (!rst_n)
    fin |-> (acc_q < dv_ext));
  // R2: completion ends the iteration
  a_r2_fin_stops: assert property (@(posedge clk) disable iff (!rst_n)
    fin |-> !run_q);
endmodule

// File: rtl/divjam_digit_split.sv
module divjam_digit_split #(
  parameter int V_W    = divjam_pkg::QUO_W,
  parameter int DIG_W  = divjam_pkg::DIG_W,
  parameter int PLACES = divjam_pkg::PLACES
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           go,
  input  logic [V_W-1:0]                 value,
  output logic [PLACES:0][DIG_W-1:0]     digits,
  output logic                           fin
);
  localparam int IDX_W = (PLACES > 1) ? $clog2(PLACES) : 1;

  logic [V_W-1:0]   pv_tab [PLACES];
  logic [V_W-1:0]   acc_q;
  logic [IDX_W-1:0] idx_q;
  logic             run_q;
  logic [DIG_W-1:0] dig_q [PLACES+1];
  logic [V_W-1:0]   cur_pv;
  logic             last_place;

  // digit slot i holds the place value 10**(PLACES-i); slot PLACES is the ones digit
  for (genvar i = 0; i < PLACES; i++) begin : g_pv
    assign pv_tab[i] = V_W'(10 ** (PLACES - i));
  end

  assign cur_pv     = pv_tab[idx_q];
  assign last_place = idx_q == IDX_W'(PLACES - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
      idx_q <= '0;
      run_q <= 1'b0;
      fin   <= 1'b0;
      for (int i = 0; i <= PLACES; i++) dig_q[i] <= '0;
    end else begin
      fin <= 1'b0;
      if (go) begin
        acc_q <= value;
        idx_q <= '0;
        run_q <= 1'b1;
        for (int i = 0; i <= PLACES; i++) dig_q[i] <= '0;
      end else if (run_q) begin
        if (acc_q >= cur_pv) begin
          acc_q        <= acc_q - cur_pv;
          dig_q[idx_q] <= dig_q[idx_q] + 1'b1;
        end else if (last_place) begin
          dig_q[PLACES] <= acc_q[DIG_W-1:0];
          run_q         <= 1'b0;
          fin           <= 1'b1;
        end else begin
          idx_q <= idx_q + 1'b1;
        end
      end
    end
  end

  for (genvar i = 0; i <= PLACES; i++) begin : g_out
    assign digits[i] = dig_q[i];
    // R4: every digit leaving the splitter is decimal
    a_r4_digit_decimal: assert property (@(posedge clk) disable iff (!rst_n)
      fin |-> (dig_q[i] <= DIG_W'(9)));
  end
endmodule

// File: rtl/divjam_pack.sv
module divjam_pack
  import divjam_pkg::*;
(
  input  logic [MODE_W-1:0] mode,
  input  logic [MOD_W-1:0]  rem,
  input  logic [DIG_W-1:0]  thou,
  input  logic [DIG_W-1:0]  hund,
  input  logic [DIG_W-1:0]  tens,
  input  logic [DIG_W-1:0]  ones,
  output logic [JAM_W-1:0]  jam_next,
  output logic [SEL_W-1:0]  ksel_next,
  output logic              thou_fits
);
  assign jam_next  = {hund, tens, ones, pack_low(mode, rem, thou)};
  assign ksel_next = kline_of(mode);
  assign thou_fits = thou <= last_cap(mode);
endmodule

// File: rtl/divjam_conv.sv
module divjam_conv
  import divjam_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [RATIO_W-1:0] ratio,
  input  logic [MODE_W-1:0]  mode_code,
  output logic               busy,
  output logic               done,
  output logic               err,
  output logic [JAM_W-1:0]   jam,
  output logic [SEL_W-1:0]   ksel
);
  typedef enum logic [1:0] {ST_IDLE, ST_DIV, ST_SPLIT} st_e;

  st_e                        st_q;
  logic [MODE_W-1:0]          mode_q;
  logic [QUO_W-1:0]           quo;
  logic [MOD_W-1:0]           rem;
  logic [PLACES:0][DIG_W-1:0] digits;
  logic [JAM_W-1:0]           jam_next;
  logic [SEL_W-1:0]           ksel_next;
  logic                       thou_fits;

  // named internal events
  logic req_legal, accept_ok, accept_bad, div_fin, split_go, split_fin, finish_ev;

  assign req_legal  = mode_known(mode_code) && (ratio >= RATIO_W'(3))
                      && (ratio <= ratio_max(mode_code));
  assign accept_ok  = (st_q == ST_IDLE) && start && req_legal;
  assign accept_bad = (st_q == ST_IDLE) && start && !req_legal;
  assign split_go   = (st_q == ST_DIV) && div_fin;
  assign finish_ev  = (st_q == ST_SPLIT) && split_fin;

  divjam_div_unit u_div (
    .clk      (clk),
    .rst_n    (rst_n),
    .go       (accept_ok),
    .dividend (ratio),
    .divisor  (mod_of(mode_code)),
    .quo      (quo),
    .rem      (rem),
    .fin      (div_fin)
  );

  divjam_digit_split u_split (
    .clk    (clk),
    .rst_n  (rst_n),
    .go     (split_go),
    .value  (quo),
    .digits (digits),
    .fin    (split_fin)
  );

  divjam_pack u_pack (
    .mode      (mode_q),
    .rem       (rem),
    .thou      (digits[0]),
    .hund      (digits[1]),
    .tens      (digits[2]),
    .ones      (digits[3]),
    .jam_next  (jam_next),
    .ksel_next (ksel_next),
    .thou_fits (thou_fits)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      mode_q <= '0;
      done   <= 1'b0;
      err    <= 1'b0;
      jam    <= '0;
      ksel   <= '0;
    end else begin
      done <= 1'b0;
      case (st_q)
        ST_IDLE: begin
          if (accept_ok) begin
            mode_q <= mode_code;
            st_q   <= ST_DIV;
          end else if (accept_bad) begin
            done <= 1'b1;
            err  <= 1'b1;
          end
        end
        ST_DIV: if (div_fin) st_q <= ST_SPLIT;
        ST_SPLIT: begin
          if (finish_ev) begin
            st_q <= ST_IDLE;
            done <= 1'b1;
            err  <= !thou_fits;
            if (thou_fits) begin
              jam  <= jam_next;
              ksel <= ksel_next;
            end
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign busy = st_q != ST_IDLE;

  // R2: completion is a single-cycle pulse
  a_r2_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R2: done never overlaps busy
  a_r2_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  // R6: a rejection leaves the preset word and select lines alone
  a_r6_err_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    (done && err) |-> ($stable(jam) && $stable(ksel)));
  // R4: outputs move only in a completion cycle
  a_r4_quiet_between: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> ($stable(jam) && $stable(ksel)));
  // R5: an accepted select code is one of the five legal patterns
  a_r5_ksel_legal: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !err) |-> (ksel inside {3'b111, 3'b011, 3'b101, 3'b001, 3'b110}));
  // R8: the divider never restarts while a conversion is pending
  a_r8_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> (busy || done));
endmodule

// File: tb/divjam_conv_bench.sv
module divjam_conv_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [13:0] ratio = '0;
  logic [2:0]  mode_code = '0;
  logic        busy, done, err;
  logic [15:0] jam;
  logic [2:0]  ksel;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;  // 125 MHz

  divjam_conv u_divjam_conv (
    .clk(clk), .rst_n(rst_n), .start(start), .ratio(ratio),
    .mode_code(mode_code), .busy(busy), .done(done), .err(err),
    .jam(jam), .ksel(ksel)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d (0x%0h) expected %0d (0x%0h)",
               req, what, act, act, exp, exp);
    end
  endtask

  function automatic int modv(input int m);
    int t[5] = '{2, 4, 5, 8, 10};
    return t[m];
  endfunction

  function automatic int exp_ksel(input int m);
    int t[5] = '{7, 3, 5, 1, 6};
    return t[m];
  endfunction

  function automatic int exp_jam(input int n, input int m);
    int d = modv(m);
    int q = n / d;
    int r = n % d;
    int rb = (m == 0) ? 1 : (m == 1) ? 2 : (m == 4) ? 4 : 3;
    int low = r + (q / 1000) * (1 << rb);
    return ((q / 100) % 10) * 4096 + ((q / 10) % 10) * 256 + (q % 10) * 16 + low;
  endfunction

  // issue one request; returns outputs at the done cycle, latency and busy after start
  task automatic run_req(input int n, input int m, output int j, output int k,
                         output bit e, output int lat, output bit busy1);
    @(negedge clk);
    ratio = 14'(n); mode_code = 3'(m); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    busy1 = busy;
    lat = 1;
    while (!done && lat < 20000) begin
      @(negedge clk);
      lat++;
    end
    j = jam; k = ksel; e = err;
  endtask

  task automatic good_case(input int n, input int m);
    int j, k, lat; bit e, b1;
    run_req(n, m, j, k, e, lat, b1);
    chk(done == 1'b1, "R2", "done seen", done, 1);
    chk(b1 == 1'b1, "R2", "busy after start", b1, 1);
    chk(busy == 1'b0, "R2", "busy low at done", busy, 0);
    chk(e == 1'b0, "R9", $sformatf("err n=%0d m=%0d", n, m), e, 0);
    chk(j == exp_jam(n, m), "R3", $sformatf("jam n=%0d m=%0d", n, m), j, exp_jam(n, m));
    chk(k == exp_ksel(m), "R5", $sformatf("ksel m=%0d", m), k, exp_ksel(m));
    @(negedge clk);
    chk(done == 1'b0, "R2", "done one cycle", done, 0);
  endtask

  task automatic bad_case(input int n, input int m);
    int j, k, lat; bit e, b1;
    int pj = jam;
    int pk = ksel;
    run_req(n, m, j, k, e, lat, b1);
    chk(lat == 1, "R6", $sformatf("reject latency n=%0d m=%0d", n, m), lat, 1);
    chk(e == 1'b1, "R6", $sformatf("err n=%0d m=%0d", n, m), e, 1);
    chk(j == pj, "R6", "jam kept", j, pj);
    chk(k == pk, "R6", "ksel kept", k, pk);
  endtask

  task automatic t_reset;
    chk(busy == 1'b0, "R1", "busy", busy, 0);
    chk(done == 1'b0, "R1", "done", done, 0);
    chk(err == 1'b0, "R1", "err", err, 0);
    chk(jam == 16'h0, "R1", "jam", jam, 0);
    chk(ksel == 3'h0, "R1", "ksel", ksel, 0);
  endtask

  task automatic t_worked;
    int j, k, lat; bit e, b1;
    run_req(8479, 2, j, k, e, lat, b1);
    chk(j == 16'h695C, "R4", "worked 8479/5 jam", j, 16'h695C);
    chk(k == 3'b101, "R5", "worked ksel", k, 5);
    chk(e == 1'b0, "R9", "worked err", e, 0);
  endtask

  task automatic t_modes;
    for (int m = 0; m < 5; m++) begin
      good_case(3, m);
      good_case(1234 + 7 * m, m);
    end
    good_case(20, 4);
    good_case(7, 3);
    good_case(6483, 1);
  endtask

  task automatic t_limits;  // R7: range maxima reach the thousands capacity
    good_case(15999, 0);
    good_case(15999, 1);
    good_case(9999, 2);
    good_case(15999, 3);
    good_case(9999, 4);
    good_case(15998, 0);
  endtask

  task automatic t_errors;
    bad_case(2, 0);
    bad_case(0, 4);
    bad_case(10000, 2);
    bad_case(10000, 4);
    bad_case(16000, 0);
    bad_case(16383, 3);
    bad_case(100, 5);
    bad_case(100, 7);
  endtask

  task automatic t_err_clear;
    bad_case(1, 1);
    good_case(500, 1);
    chk(err == 1'b0, "R9", "err stays clear", err, 0);
  endtask

  task automatic t_busy_ignore;
    int lat;
    @(negedge clk);
    ratio = 14'd4321; mode_code = 3'd3; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (5) @(negedge clk);
    ratio = 14'd77; mode_code = 3'd4; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    ratio = 14'd0;
    lat = 0;
    while (!done && lat < 20000) begin
      @(negedge clk);
      lat++;
    end
    chk(jam == exp_jam(4321, 3), "R8", "first request kept", jam, exp_jam(4321, 3));
    chk(ksel == 3'b001, "R8", "first ksel kept", ksel, 1);
    lat = 0;
    repeat (40) begin
      @(negedge clk);
      if (done || busy) lat++;
    end
    chk(lat == 0, "R8", "no second conversion", lat, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_worked;
    t_modes;
    t_limits;
    t_errors;
    t_err_clear;
    t_busy_ignore;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule